// File: doc/BRIEF.md
# Four-Lane Polyphase FIR Filter

This block is a fixed-coefficient FIR filter for sample rates above the clock rate. On every clock where the valid flag is high, it accepts one frame of four consecutive signed samples. Two cycles later it returns four consecutive filtered samples, one for each input time index. The filter is split into one branch per output phase. Each branch forms every tap product for its phase in parallel. Symmetric coefficients do not share multipliers, so the block trades multiplier count for a rate of four samples per clock.

A register file holds the most recent taps-minus-one samples across frame boundaries. A long stream cut into frames therefore filters exactly as if it had been fed one sample per clock. Cycles without valid leave the history and the output untouched. The output keeps the full width of the sum, so no rounding or wrap occurs.

Top module: `pfir_quad`

## Requirements
- R1: Lane e of `in_frame` sits in bits [16e+15:16e], and lane 0 is the oldest sample of the frame. Lane e of `out_frame` sits in bits [ACC_W·e+ACC_W−1 : ACC_W·e] and belongs to the same time index as input lane e.
- R2: Output lane for stream index n equals the sum over k = 0..TAPS−1 of h[k]·x[n−k]. Here h[k] = +((k mod 11)+1)·2731 for even k and the negative of that for odd k, and x is the stream of signed 16-bit samples.
- R3: Samples from earlier valid frames, up to TAPS−1 positions back, contribute to the current frame's outputs, so convolution runs on without a break at frame edges.
- R4: A cycle with `in_valid` low changes neither the sample history nor `out_frame`, whatever `in_frame` carries. `out_frame` holds its value while `out_valid` is low.
- R5: `out_valid` is high exactly two clocks after each clock on which `in_valid` was high, and at no other time.
- R6: Outputs are signed, ACC_W = 32 + ceil(log2(TAPS)) bits wide (36 at the default TAPS = 10), and never wrap, even for full-scale inputs whose signs line up with the coefficient signs.
- R7: A synchronous active-high reset clears `out_valid`, `out_frame` and the history. Samples seen before reset then count as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Frame on `in_frame` is valid this cycle |
| in_frame | input | 64 | Four signed Q1.15 samples, lane 0 oldest |
| out_valid | output | 1 | `out_frame` carries a new result |
| out_frame | output | 4·ACC_W | Four full-precision signed results, lane 0 oldest |

## Verification
The hardest case to reach is a tap whose sample lies several frames back, with invalid cycles in between and garbage on the data inputs during those gaps. The stimulus sends a single impulse at each lane position with several amplitudes, followed by zero frames, so that every coefficient appears in a known lane of a later frame. Long pseudo-random streams with random idle gaps follow, and a full-scale pattern with alternating signs drives the sum past 32 bits. A reset in the middle of a stream that has nonzero history shows that the older samples no longer contribute.

// File: rtl/pfir_pkg.sv
package pfir_pkg;
  localparam int SAMPLE_W = 16;
  localparam int COEF_W   = 16;
  localparam int PROD_W   = SAMPLE_W + COEF_W;
  localparam int COEF_STEP = 2731;
  localparam int COEF_WRAP = 11;

  // Fixed coefficient set: magnitude ramps and wraps, sign alternates.
  function automatic logic signed [COEF_W-1:0] coef_at(input int k);
    int mag;
    mag = ((k % COEF_WRAP) + 1) * COEF_STEP;
    if (k % 2 == 1) return COEF_W'(-mag);
    return COEF_W'(mag);
  endfunction

  // Full-precision signed product of one sample and one coefficient.
  function automatic logic signed [PROD_W-1:0] mul_tap(
    input logic signed [SAMPLE_W-1:0] s,
    input logic signed [COEF_W-1:0]   c
  );
    logic signed [PROD_W-1:0] a;
    logic signed [PROD_W-1:0] b;
    a = PROD_W'(s);
    b = PROD_W'(c);
    return a * b;
  endfunction
endpackage

// File: rtl/pfir_history.sv
module pfir_history import pfir_pkg::*; #(
  parameter int TAPS  = 10,
  parameter int LANES = 4,
  localparam int HIST_N = TAPS - 1,
  localparam int WIN_N  = HIST_N + LANES
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         in_valid,
  input  logic [LANES*SAMPLE_W-1:0]    in_frame,
  output logic [WIN_N*SAMPLE_W-1:0]    window
);
  logic [SAMPLE_W-1:0] hist_q [HIST_N];
  logic [HIST_N*SAMPLE_W-1:0] hist_view;

  for (genvar i = 0; i < HIST_N; i++) begin : g_hist
    assign window[i*SAMPLE_W +: SAMPLE_W] = hist_q[i];
  end
  for (genvar e = 0; e < LANES; e++) begin : g_new
    assign window[(HIST_N+e)*SAMPLE_W +: SAMPLE_W] = in_frame[e*SAMPLE_W +: SAMPLE_W];
  end
  assign hist_view = window[HIST_N*SAMPLE_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < HIST_N; i++) hist_q[i] <= '0;
    end else if (in_valid) begin
      for (int i = 0; i < HIST_N; i++)
        hist_q[i] <= window[(i+LANES)*SAMPLE_W +: SAMPLE_W];
    end
  end

  // R3
  carry_newest_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> hist_q[HIST_N-1] == $past(in_frame[(LANES-1)*SAMPLE_W +: SAMPLE_W]));

  // R4
  hist_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(hist_view));
endmodule

// File: rtl/pfir_branch.sv
module pfir_branch import pfir_pkg::*; #(
  parameter int TAPS  = 10,
  parameter int LANES = 4,
  parameter int LANE  = 0,
  localparam int HIST_N = TAPS - 1,
  localparam int WIN_N  = HIST_N + LANES,
  localparam int ACC_W  = PROD_W + $clog2(TAPS)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      ld_prod,
  input  logic                      ld_sum,
  input  logic [WIN_N*SAMPLE_W-1:0] window,
  output logic signed [ACC_W-1:0]   sum_q
);
  logic signed [PROD_W-1:0] prod_d [TAPS];
  logic signed [PROD_W-1:0] prod_q [TAPS];
  logic signed [ACC_W-1:0]  sum_d;

  // Tap k of this phase reads the sample k positions before this lane.
  for (genvar k = 0; k < TAPS; k++) begin : g_tap
    assign prod_d[k] = mul_tap(window[(HIST_N+LANE-k)*SAMPLE_W +: SAMPLE_W], coef_at(k));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < TAPS; k++) prod_q[k] <= '0;
    end else if (ld_prod) begin
      for (int k = 0; k < TAPS; k++) prod_q[k] <= prod_d[k];
    end
  end

  always_comb begin
    sum_d = '0;
    for (int k = 0; k < TAPS; k++) sum_d = sum_d + ACC_W'(prod_q[k]);
  end

  always_ff @(posedge clk) begin
    if (rst)         sum_q <= '0;
    else if (ld_sum) sum_q <= sum_d;
  end
endmodule

// File: rtl/pfir_quad.sv
module pfir_quad import pfir_pkg::*; #(
  parameter int TAPS  = 10,
  parameter int LANES = 4,
  localparam int HIST_N = TAPS - 1,
  localparam int WIN_N  = HIST_N + LANES,
  localparam int ACC_W  = PROD_W + $clog2(TAPS)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_valid,
  input  logic [LANES*SAMPLE_W-1:0] in_frame,
  output logic                      out_valid,
  output logic [LANES*ACC_W-1:0]    out_frame
);
  logic [WIN_N*SAMPLE_W-1:0] window;
  logic                      s1_valid;
  logic signed [ACC_W-1:0]   lane_sum [LANES];

  pfir_history #(.TAPS(TAPS), .LANES(LANES)) u_hist (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_frame(in_frame), .window(window)
  );

  for (genvar e = 0; e < LANES; e++) begin : g_branch
    pfir_branch #(.TAPS(TAPS), .LANES(LANES), .LANE(e)) u_br (
      .clk(clk), .rst(rst), .ld_prod(in_valid), .ld_sum(s1_valid),
      .window(window), .sum_q(lane_sum[e])
    );
    assign out_frame[e*ACC_W +: ACC_W] = lane_sum[e];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid  <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      s1_valid  <= in_valid;
      out_valid <= s1_valid;
    end
  end

  // R5
  lat_rise_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> ##2 out_valid);

  // R5
  lat_only_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid, 2));

  // R4
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!out_valid && !$past(rst)) |-> $stable(out_frame));
endmodule

// File: tb/pfir_quad_test.sv
module pfir_quad_test;
  localparam int TAPS  = 10;
  localparam int LANES = 4;
  localparam int SW    = 16;
  localparam int ACC_W = 32 + $clog2(TAPS);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [LANES*SW-1:0] in_frame = '0;
  logic out_valid;
  logic [LANES*ACC_W-1:0] out_frame;

  pfir_quad #(.TAPS(TAPS), .LANES(LANES)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_frame(in_frame),
    .out_valid(out_valid), .out_frame(out_frame)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int failures = 0;
  string tag = "R2";
  longint xs [0:4095];
  int nsamp = 0;
  longint exp_q [$];
  logic [1:0] vpipe = 2'b00;
  logic [LANES*ACC_W-1:0] last_out = '0;
  int unsigned seed = 32'h1234_5678;

  function automatic longint h_of(input int k);
    longint m;
    m = longint'((k % 11) + 1) * 2731;
    return ((k & 1) != 0) ? -m : m;
  endfunction

  function automatic int unsigned nxt(input int unsigned s);
    int unsigned v;
    v = s ^ (s << 13);
    v = v ^ (v >> 17);
    v = v ^ (v << 5);
    return v;
  endfunction

  task automatic chk(input string t, input longint got, input longint want, input string what);
    checks++;
    if (got != want) begin
      failures++;
      $display("FAIL %s %s got=%0d expected=%0d", t, what, got, want);
    end
  endtask

  task automatic step(input logic v, input longint fr [LANES]);
    @(negedge clk);
    chk("R5", longint'(out_valid), longint'(vpipe[1]), "out_valid");
    if (out_valid) begin
      for (int e = 0; e < LANES; e++) begin
        longint got;
        longint want;
        got  = longint'($signed(out_frame[e*ACC_W +: ACC_W]));
        want = (exp_q.size() > 0) ? exp_q.pop_front() : 64'sd0;
        chk(tag, got, want, $sformatf("lane%0d", e));
      end
    end else begin
      checks++;
      if (out_frame !== last_out) begin
        failures++;
        $display("FAIL R4 out_frame moved while idle got=%h expected=%h", out_frame, last_out);
      end
    end
    last_out = out_frame;
    in_valid = v;
    for (int e = 0; e < LANES; e++) in_frame[e*SW +: SW] = SW'(fr[e]);
    if (v) begin
      for (int e = 0; e < LANES; e++) xs[nsamp+e] = fr[e];
      for (int e = 0; e < LANES; e++) begin
        longint acc = 0;
        for (int k = 0; k < TAPS; k++)
          if (nsamp + e - k >= 0) acc += h_of(k) * xs[nsamp+e-k];
        exp_q.push_back(acc);
      end
      nsamp += LANES;
    end
    vpipe = {vpipe[0], v};
  endtask

  task automatic idle(input int n);
    longint z [LANES];
    for (int i = 0; i < n; i++) begin
      seed = nxt(seed);
      for (int e = 0; e < LANES; e++) z[e] = longint'($signed(SW'(seed >> e)));
      step(1'b0, z);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R7", longint'(out_valid), 0, "out_valid after reset");
    checks++;
    if (out_frame !== '0) begin
      failures++;
      $display("FAIL R7 out_frame after reset got=%h expected=0", out_frame);
    end
    nsamp = 0;
    exp_q.delete();
    vpipe = 2'b00;
    last_out = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired got=hang expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    longint fr [LANES];
    longint amps [4] = '{1, -1, 32767, -32768};
    do_reset();

    // R1: impulse at each lane, several amplitudes, ordering of lanes
    tag = "R1";
    for (int a = 0; a < 4; a++)
      for (int p = 0; p < LANES; p++) begin
        for (int e = 0; e < LANES; e++) fr[e] = (e == p) ? amps[a] : 0;
        step(1'b1, fr);
        for (int e = 0; e < LANES; e++) fr[e] = 0;
        repeat (3) step(1'b1, fr);
      end
    idle(3);

    // R3: impulse in the newest lane, taps reach into following frames
    tag = "R3";
    for (int e = 0; e < LANES; e++) fr[e] = (e == 3) ? 1000 : 0;
    step(1'b1, fr);
    for (int e = 0; e < LANES; e++) fr[e] = 0;
    repeat (3) step(1'b1, fr);
    idle(3);

    // R6: full scale, signs aligned with coefficient signs
    tag = "R6";
    for (int f = 0; f < 6; f++) begin
      for (int e = 0; e < LANES; e++) fr[e] = ((nsamp + e) % 2 == 0) ? -32768 : 32767;
      step(1'b1, fr);
    end
    idle(3);

    // R2: pseudo-random back-to-back stream
    tag = "R2";
    for (int f = 0; f < 200; f++) begin
      for (int e = 0; e < LANES; e++) begin
        seed = nxt(seed);
        fr[e] = longint'($signed(SW'(seed)));
      end
      step(1'b1, fr);
    end
    idle(3);

    // R4: random stream with garbage-filled idle gaps
    tag = "R4";
    for (int f = 0; f < 200; f++) begin
      for (int e = 0; e < LANES; e++) begin
        seed = nxt(seed);
        fr[e] = longint'($signed(SW'(seed >> 7)));
      end
      step(1'b1, fr);
      seed = nxt(seed);
      idle(int'(seed % 3));
    end
    idle(3);

    // R7: reset with nonzero history, old samples must not contribute
    for (int e = 0; e < LANES; e++) fr[e] = 30000;
    repeat (3) step(1'b1, fr);
    do_reset();
    tag = "R7";
    for (int e = 0; e < LANES; e++) fr[e] = (e == 0) ? 5 : 0;
    repeat (4) step(1'b1, fr);
    idle(4);

    chk("R5", longint'(exp_q.size()), 0, "pending results at end");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule